// File: doc/BRIEF.md
# Channel-Attention Command Decoder for a Descriptor-Driven Ethernet Controller

This block holds the run state of the two engines of a descriptor-driven Ethernet controller: the command unit, which walks a list of host commands, and the receive unit, which fills frame descriptors. The host places a 16-bit command word in the block and then raises a channel-attention pulse. The block takes the word in, clears it, and decodes four fields:

- acknowledge bits, each of which clears one latched event flag;
- a command-unit opcode;
- a receive-unit opcode;
- a software-reset request.

The block then publishes a 16-bit status word. That word holds the four event flags and the encoded state of each unit.

After each decode in which the command unit is not left suspended, the block sends a one-cycle start pulse to the command-list walker. It adds a pointer-reload pulse when no list is in progress or when a reset was requested. A reset also produces a pointer-clear pulse.

The list walker and the receive path report their events through dedicated strobes. These strobes set flags and can suspend either unit at any time. Attention pulses that arrive while a decode is running are counted and replayed later, so none is lost.

Top module: `scb_cmd_decoder`

## Requirements
- R1: After reset the status word reads 0x0010 (command unit idle, receive unit suspended, no flags), the command word reads 0, and the start, reload, clear and error outputs are low.
- R2: Status bits 11:8 carry the command-unit state (idle=0, suspended=1, active=2). Command-unit opcode 1, taken from command bits 10:8, makes that unit active. Opcode 0 changes nothing.
- R3: Command-unit opcode 4 suspends that unit and sets status bit 13 (command unit left active).
- R4: Status bits 7:4 carry the receive-unit state (idle=0, suspended=1, ready=4). Receive-unit opcodes 1 and 2, taken from command bits 6:4, move that unit to idle. Opcodes 3 and 4 suspend it and set status bit 12.
- R5: A one in command bit 15, 14, 13 or 12 clears the status flag in the same bit position. A set event arriving in the same cycle as the decode wins over the acknowledge.
- R6: Each event strobe acts on the status word one clock after it is sampled:
  - the command-done-with-interrupt strobe sets bit 15;
  - the frame-received strobe sets bit 14;
  - the command-unit suspend strobe moves that unit to suspended;
  - the receive-unit suspend strobe moves that unit to suspended and sets bit 12.
- R7: Command bit 7 forces the command unit to idle, the receive unit to suspended and all flags to zero, whatever the opcodes say, and it pulses the pointer-clear output for one cycle.
- R8: The command word reads 0 once the decoder has consumed it, two clocks after the attention edge.
- R9: The list-start output pulses for one cycle after a decode that leaves the command unit not suspended. The pointer-reload output pulses with it only when the list-busy input is low or bit 7 was set.
- R10: An opcode value other than those listed (command unit: 2, 3, 5, 6, 7; receive unit: 5, 6, 7) leaves that unit's state unchanged and pulses the error output for one cycle.
- R11: An attention pulse that arrives during a decode is counted and decoded after the current one, using the command word present at that later time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 16 | Command word written by the host |
| attn | input | 1 | Channel-attention pulse |
| list_busy | input | 1 | High while the command-list walker holds a live list |
| ev_cmd_intr | input | 1 | Walker finished a command that requests an interrupt |
| ev_frame | input | 1 | Receive path finished a frame |
| ev_cu_susp | input | 1 | Walker met a suspend-after-command mark |
| ev_ru_susp | input | 1 | Receive path ran out and suspended |
| cmd_word | output | 16 | Command word as currently held |
| status_word | output | 16 | Flags, command-unit and receive-unit state |
| list_start | output | 1 | One-cycle start pulse to the list walker |
| list_load | output | 1 | One-cycle request to reload the list pointer |
| ptr_clear | output | 1 | One-cycle request to null the command pointer |
| op_err | output | 1 | One-cycle strobe for an unrecognised opcode |

## Verification
Take the clock edge that samples the attention pulse as edge k. The command word reads zero after edge k+2. The status word and the start, reload, clear and error pulses are updated at edge k+3, and the pulses fall again at edge k+4. An event strobe shows in the status word one edge after it is sampled.

The bench drives inputs on falling edges and counts falling edges from the attention edge before each sample. The acknowledge-versus-event race is placed so that the strobe is sampled exactly on edge k+3. The replay case is placed so that the second attention lands while the first decode is still executing.

// File: rtl/scb_pkg.sv
package scb_pkg;

  localparam int CMD_W    = 16;
  localparam int OP_W     = 3;
  localparam int FLAG_N   = 4;
  localparam int ACK_LSB  = 12;
  localparam int CUC_LSB  = 8;
  localparam int RUC_LSB  = 4;
  localparam int SRST_BIT = 7;

  // flag index inside the 4-bit nibble (status bits 15:12)
  localparam int FLG_CX  = 3;
  localparam int FLG_FR  = 2;
  localparam int FLG_CNA = 1;
  localparam int FLG_RNR = 0;

  typedef enum logic [3:0] {
    CU_IDLE = 4'd0,
    CU_SUSP = 4'd1,
    CU_ACT  = 4'd2
  } cu_state_t;

  typedef enum logic [3:0] {
    RU_IDLE  = 4'd0,
    RU_SUSP  = 4'd1,
    RU_READY = 4'd4
  } ru_state_t;

  typedef enum logic [1:0] {
    DEC_IDLE  = 2'd0,
    DEC_FETCH = 2'd1,
    DEC_EXEC  = 2'd2
  } dec_state_t;

  typedef struct packed {
    logic [FLAG_N-1:0] ack;
    logic [OP_W-1:0]   cuc;
    logic [OP_W-1:0]   ruc;
    logic              srst;
  } cmd_fields_t;

  function automatic cmd_fields_t split_cmd(input logic [CMD_W-1:0] w);
    cmd_fields_t f;
    f.ack  = w[ACK_LSB +: FLAG_N];
    f.cuc  = w[CUC_LSB +: OP_W];
    f.ruc  = w[RUC_LSB +: OP_W];
    f.srst = w[SRST_BIT];
    return f;
  endfunction

endpackage

// File: rtl/scb_attn_queue.sv
module scb_attn_queue #(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic attn,
  input  logic take,
  output logic pending
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             inc, dec;

  assign inc     = attn && (cnt_q != CNT_MAX || take);
  assign dec     = take && (cnt_q != '0);
  assign pending = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (inc && !dec) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec && !inc) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_TAKE_DRAINS_ONE: assert property (@(posedge clk) disable iff (rst)
    (take && !attn) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R11

  AST_ATTN_COUNTED: assert property (@(posedge clk) disable iff (rst)
    (attn && !take && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R11

endmodule

// File: rtl/scb_unit_ctrl.sv
module scb_unit_ctrl
  import scb_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            apply,
  input  logic [OPW-1:0]  cuc,
  input  logic [OPW-1:0]  ruc,
  input  logic            soft_rst,
  input  logic            ev_cu_susp,
  input  logic            ev_ru_susp,
  output cu_state_t       cu_q,
  output ru_state_t       ru_q,
  output cu_state_t       cu_n,
  output logic            cu_left,
  output logic            ru_left,
  output logic            bad_op
);

  ru_state_t ru_n;

  always_comb begin
    cu_n    = cu_q;
    ru_n    = ru_q;
    cu_left = 1'b0;
    ru_left = 1'b0;
    bad_op  = 1'b0;
    if (ev_cu_susp) cu_n = CU_SUSP;
    if (ev_ru_susp) ru_n = RU_SUSP;
    if (apply) begin
      case (cuc)
        OPW'(0): ;
        OPW'(1): cu_n = CU_ACT;
        OPW'(4): begin
          cu_n    = CU_SUSP;
          cu_left = 1'b1;
        end
        default: bad_op = 1'b1;
      endcase
      case (ruc)
        OPW'(0): ;
        OPW'(1), OPW'(2): ru_n = RU_IDLE;
        OPW'(3), OPW'(4): begin
          ru_n    = RU_SUSP;
          ru_left = 1'b1;
        end
        default: bad_op = 1'b1;
      endcase
      if (soft_rst) begin
        cu_n    = CU_IDLE;
        ru_n    = RU_SUSP;
        cu_left = 1'b0;
        ru_left = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cu_q <= CU_IDLE;
      ru_q <= RU_SUSP;
    end else begin
      cu_q <= cu_n;
      ru_q <= ru_n;
    end
  end

  AST_SRST_UNITS: assert property (@(posedge clk) disable iff (rst)
    (apply && soft_rst) |=> (cu_q == CU_IDLE && ru_q == RU_SUSP)); // R7

  AST_CU_ABORT: assert property (@(posedge clk) disable iff (rst)
    (apply && !soft_rst && cuc == OPW'(4)) |=> (cu_q == CU_SUSP)); // R3

  AST_RU_SUSP_EV: assert property (@(posedge clk) disable iff (rst)
    (ev_ru_susp && !(apply && (ruc == OPW'(1) || ruc == OPW'(2))))
      |=> (ru_q == RU_SUSP)); // R6

endmodule

// File: rtl/scb_event_flags.sv
module scb_event_flags #(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             apply,
  input  logic             soft_rst,
  input  logic [NFLAG-1:0] ack,
  input  logic [NFLAG-1:0] set,
  output logic [NFLAG-1:0] flags
);

  logic [NFLAG-1:0] clr_mask;

  assign clr_mask = apply ? ack : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (apply && soft_rst) begin
      flags <= '0;
    end else begin
      flags <= (flags & ~clr_mask) | set;
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (apply && !soft_rst && ((ack & ~set) != '0))
      |=> ((flags & $past(ack & ~set)) == '0)); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (!(apply && soft_rst) && set != '0) |=> ((flags & $past(set)) == $past(set))); // R5

endmodule

// File: rtl/scb_cmd_decoder.sv
module scb_cmd_decoder
  import scb_pkg::*;
#(
  parameter int ATTN_CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              attn,
  input  logic              list_busy,
  input  logic              ev_cmd_intr,
  input  logic              ev_frame,
  input  logic              ev_cu_susp,
  input  logic              ev_ru_susp,
  output logic [CMD_W-1:0]  cmd_word,
  output logic [CMD_W-1:0]  status_word,
  output logic              list_start,
  output logic              list_load,
  output logic              ptr_clear,
  output logic              op_err
);

  dec_state_t       st_q;
  cmd_fields_t      lat_q;
  logic             pending, take, apply;
  cu_state_t        cu_q, cu_n;
  ru_state_t        ru_q;
  logic             cu_left, ru_left, bad_op;
  logic [FLAG_N-1:0] flags, set_vec;

  assign take  = (st_q == DEC_IDLE) && pending;
  assign apply = (st_q == DEC_EXEC);

  scb_attn_queue #(.CNT_W(ATTN_CNT_W)) u_queue (
    .clk     (clk),
    .rst     (rst),
    .attn    (attn),
    .take    (take),
    .pending (pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= DEC_IDLE;
      lat_q    <= '0;
      cmd_word <= '0;
    end else begin
      case (st_q)
        DEC_IDLE:  if (pending) st_q <= DEC_FETCH;
        DEC_FETCH: begin
          lat_q <= split_cmd(cmd_word);
          st_q  <= DEC_EXEC;
        end
        default:   st_q <= DEC_IDLE;
      endcase
      if (cmd_wr) begin
        cmd_word <= cmd_wdata;
      end else if (st_q == DEC_FETCH) begin
        cmd_word <= '0;
      end
    end
  end

  scb_unit_ctrl #(.OPW(OP_W)) u_units (
    .clk        (clk),
    .rst        (rst),
    .apply      (apply),
    .cuc        (lat_q.cuc),
    .ruc        (lat_q.ruc),
    .soft_rst   (lat_q.srst),
    .ev_cu_susp (ev_cu_susp),
    .ev_ru_susp (ev_ru_susp),
    .cu_q       (cu_q),
    .ru_q       (ru_q),
    .cu_n       (cu_n),
    .cu_left    (cu_left),
    .ru_left    (ru_left),
    .bad_op     (bad_op)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_CX]  = ev_cmd_intr;
    set_vec[FLG_FR]  = ev_frame;
    set_vec[FLG_CNA] = cu_left;
    set_vec[FLG_RNR] = ru_left || ev_ru_susp;
  end

  scb_event_flags #(.NFLAG(FLAG_N)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .apply    (apply),
    .soft_rst (lat_q.srst),
    .ack      (lat_q.ack),
    .set      (set_vec),
    .flags    (flags)
  );

  assign status_word = {flags, cu_q, ru_q, 4'b0000};

  always_ff @(posedge clk) begin
    if (rst) begin
      list_start <= 1'b0;
      list_load  <= 1'b0;
      ptr_clear  <= 1'b0;
      op_err     <= 1'b0;
    end else begin
      list_start <= apply && (cu_n != CU_SUSP);
      list_load  <= apply && (cu_n != CU_SUSP) && (!list_busy || lat_q.srst);
      ptr_clear  <= apply && lat_q.srst;
      op_err     <= apply && bad_op;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    list_start |=> !list_start); // R9

  AST_START_NOT_SUSP: assert property (@(posedge clk) disable iff (rst)
    (list_start && !$past(ev_cu_susp)) |-> (status_word[11:8] != 4'd1)); // R9

  AST_LOAD_WITH_START: assert property (@(posedge clk) disable iff (rst)
    list_load |-> list_start); // R9

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    op_err |=> !op_err); // R10

  AST_CMD_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    (st_q == DEC_FETCH && !cmd_wr) |=> (cmd_word == '0)); // R8

endmodule

// File: tb/scb_cmd_decoder_tb.sv
module scb_cmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_wr;
  logic [15:0] cmd_wdata;
  logic        attn, list_busy;
  logic        ev_cmd_intr, ev_frame, ev_cu_susp, ev_ru_susp;
  logic [15:0] cmd_word, status_word;
  logic        list_start, list_load, ptr_clear, op_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scb_cmd_decoder u_dut (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr      (cmd_wr),
    .cmd_wdata   (cmd_wdata),
    .attn        (attn),
    .list_busy   (list_busy),
    .ev_cmd_intr (ev_cmd_intr),
    .ev_frame    (ev_frame),
    .ev_cu_susp  (ev_cu_susp),
    .ev_ru_susp  (ev_ru_susp),
    .cmd_word    (cmd_word),
    .status_word (status_word),
    .list_start  (list_start),
    .list_load   (list_load),
    .ptr_clear   (ptr_clear),
    .op_err      (op_err)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write the word, then pulse attention; returns at the falling edge after edge k
  task automatic issue(input logic [15:0] w);
    cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0; attn = 1'b1;
    @(negedge clk);
    attn = 1'b0;
  endtask

  // issue and sample the decoded results at edge k+3
  task automatic decode(input logic [15:0] w);
    issue(w);
    negs(2);
    check("R8", "command word consumed", cmd_word, 16'h0000);
    negs(1);
  endtask

  task automatic strobe(input logic a, input logic b, input logic c, input logic d);
    ev_cmd_intr = a; ev_frame = b; ev_cu_susp = c; ev_ru_susp = d;
    @(negedge clk);
    ev_cmd_intr = 0; ev_frame = 0; ev_cu_susp = 0; ev_ru_susp = 0;
  endtask

  task automatic t_reset;
    check("R1", "status after reset", status_word, 16'h0010);
    check("R1", "command word after reset", cmd_word, 16'h0000);
    check("R1", "pulses after reset", {12'd0, list_start, list_load, ptr_clear, op_err}, 16'h0);
  endtask

  task automatic t_cu_start;
    decode(16'h0100);
    check("R2", "cu active", status_word, 16'h0210);
    check("R9", "start+load, list idle", {14'd0, list_start, list_load}, 16'h3);
    negs(1);
    check("R9", "start is one cycle", {15'd0, list_start}, 16'h0);
  endtask

  task automatic t_ru_start_busy;
    list_busy = 1'b1;
    decode(16'h0010);
    check("R4", "ru idle", status_word, 16'h0200);
    check("R9", "start without reload while busy", {14'd0, list_start, list_load}, 16'h2);
    list_busy = 1'b0;
  endtask

  task automatic t_cu_abort;
    decode(16'h0400);
    check("R3", "cu suspended, flag 13", status_word, 16'h2100);
    check("R9", "no start when suspended", {15'd0, list_start}, 16'h0);
  endtask

  task automatic t_ru_ops;
    decode(16'h0030);
    check("R4", "ru suspend sets flag 12", status_word, 16'h3110);
    decode(16'h0020);
    check("R4", "ru resume to idle", status_word, 16'h3100);
    decode(16'h0040);
    check("R4", "ru abort", status_word, 16'h3110);
  endtask

  task automatic t_events_acks;
    strobe(1, 0, 0, 0);
    check("R6", "cmd-intr sets 15", status_word, 16'hB110);
    strobe(0, 1, 0, 0);
    check("R6", "frame sets 14", status_word, 16'hF110);
    decode(16'h3100);
    check("R5", "ack 13,12 with cu start", status_word, 16'hC210);
    strobe(0, 0, 1, 0);
    check("R6", "cu suspend strobe", status_word, 16'hC110);
    strobe(0, 0, 0, 1);
    check("R6", "ru suspend strobe sets 12", status_word, 16'hD110);
    // frame strobe sampled on the decode edge while acking bit 14
    issue(16'h4000);
    negs(2);
    ev_frame = 1'b1;
    @(negedge clk);
    ev_frame = 1'b0;
    check("R5", "event beats ack", status_word, 16'hD110);
    decode(16'hF000);
    check("R5", "ack all flags", status_word, 16'h0110);
  endtask

  task automatic t_bad_ops;
    decode(16'h0300);
    check("R10", "bad cu op strobe", {15'd0, op_err}, 16'h1);
    check("R10", "bad cu op keeps state", status_word, 16'h0110);
    negs(1);
    check("R10", "error strobe one cycle", {15'd0, op_err}, 16'h0);
    decode(16'h0070);
    check("R10", "bad ru op strobe", {15'd0, op_err}, 16'h1);
    check("R10", "bad ru op keeps state", status_word, 16'h0110);
  endtask

  task automatic t_soft_reset;
    decode(16'h0100);
    strobe(1, 0, 0, 0);
    check("R6", "setup before reset", status_word, 16'h8210);
    list_busy = 1'b1;
    decode(16'h0190);
    check("R7", "soft reset state", status_word, 16'h0010);
    check("R7", "pointer clear pulse", {15'd0, ptr_clear}, 16'h1);
    check("R9", "start+load forced by reset", {14'd0, list_start, list_load}, 16'h3);
    list_busy = 1'b0;
    negs(1);
    check("R7", "pointer clear one cycle", {15'd0, ptr_clear}, 16'h0);
  endtask

  task automatic t_replay;
    issue(16'h0400);
    negs(2);
    cmd_wr = 1'b1; cmd_wdata = 16'h0100; attn = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0; attn = 1'b0;
    check("R11", "first decode applied", status_word, 16'h2110);
    negs(3);
    check("R11", "second attention replayed", status_word, 16'h2210);
  endtask

  initial begin
    rst = 1'b1; cmd_wr = 0; cmd_wdata = 0; attn = 0; list_busy = 0;
    ev_cmd_intr = 0; ev_frame = 0; ev_cu_susp = 0; ev_ru_susp = 0;
    negs(4);
    rst = 1'b0;
    negs(1);
    t_reset();
    t_cu_start();
    t_ru_start_busy();
    t_cu_abort();
    t_ru_ops();
    t_events_acks();
    t_bad_ops();
    t_soft_reset();
    t_replay();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule